// File: doc/BRIEF.md
# Configurable Valid/Ready Pipeline Register Slice

This block is one register stage placed in a streaming path that uses a valid/ready handshake. A beat moves across a port only in a cycle where that port's valid and ready are both high. The stage sits between an upstream producer and a downstream consumer and passes every beat through unchanged. It never loses a beat, never repeats one and never reorders them. Its purpose is to break a long timing path without changing the behaviour of the stream.

An elaboration parameter picks which path is broken. The full variant registers both directions. It uses a main register and a skid register, and it accepts and delivers one beat per cycle while the stream is not stalled. The forward variant registers only valid and data, using one data register, and lets the downstream ready reach the upstream side through logic. The backward variant registers only the ready, using one data register, and lets upstream valid and data pass through logic. When this variant's buffer is holding a beat, that beat goes downstream before any new input. Reset clears every valid flag. The data registers have no reset.

Top module: `stream_reg_slice`

## Requirements
- R1: `dn_valid` is high only while a beat that was accepted upstream and not yet delivered is being presented. A beat presented through the backward variant's pass-through counts as accepted in the same cycle.
- R2: Every beat accepted on the upstream port leaves the downstream port exactly once, in the order it was accepted, with its data unchanged.
- R3: If `dn_valid` is high and `dn_ready` is low, then in the next cycle `dn_valid` is still high and `dn_data` has not changed.
- R4: In the full variant (MODE 0), `up_ready`, `dn_valid` and `dn_data` do not change within a cycle when `dn_ready`, `up_valid` or `up_data` change.
- R5: In the forward variant (MODE 1), `dn_valid` and `dn_data` do not change within a cycle when `up_valid` or `up_data` change. A beat accepted upstream is on `dn_data`, with `dn_valid` high, in the next cycle.
- R6: In the backward variant (MODE 2), `up_ready` does not change within a cycle when `dn_ready` changes. While `up_ready` is high, `dn_valid` equals `up_valid` and, when valid, `dn_data` equals `up_data`.
- R7: In every variant, `up_ready` low implies `dn_valid` high. A held beat is always offered downstream ahead of new input.
- R8: In the full variant, with `up_valid` and `dn_ready` held high, one beat is accepted and one is delivered in every cycle once the pipe is filled.
- R9: While `rst_n` is low and `up_valid` is low, `dn_valid` is low and `up_ready` is high.
- R10: The number of beats accepted but not yet delivered never exceeds 2 in the full variant or 1 in the forward and backward variants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream beat offered |
| up_ready | output | 1 | Stage can take an upstream beat |
| up_data | input | DATA_W | Upstream beat payload |
| dn_valid | output | 1 | Downstream beat offered |
| dn_ready | input | 1 | Downstream consumer takes the beat |
| dn_data | output | DATA_W | Downstream beat payload |

## Verification
The hardest case to reach is a stall that arrives while the full variant's main register is occupied and a new beat arrives in the same cycle, which forces the skid register to fill. Long stalls are followed by release cycles in which upstream keeps offering beats. The bench covers this with phases that pair a high offer rate with a low acceptance rate, and the reverse. Claims that no path exists through the block are checked in the middle of each cycle: the bench briefly flips the opposite-side inputs, checks that the registered outputs do not move, and restores the inputs before the clock edge.

// File: rtl/stream_slice_pkg.sv
package stream_slice_pkg;

   typedef enum logic [1:0] {
      SLICE_FULL = 2'd0,
      SLICE_FWD  = 2'd1,
      SLICE_BWD  = 2'd2
   } slice_mode_e;

   // beats a variant can hold at once
   function automatic int slice_depth(slice_mode_e m);
      return (m == SLICE_FULL) ? 2 : 1;
   endfunction

endpackage

// File: rtl/slice_full.sv
module slice_full #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid_i,
   output logic              up_ready_o,
   input  logic [DATA_W-1:0] up_data_i,
   output logic              dn_valid_o,
   input  logic              dn_ready_i,
   output logic [DATA_W-1:0] dn_data_o
);

   logic              main_vld;
   logic              skid_vld;
   logic [DATA_W-1:0] main_dat;
   logic [DATA_W-1:0] skid_dat;
   logic              take_up;
   logic              main_free;

   // ready comes straight from the skid flag register
   assign up_ready_o = ~skid_vld;
   assign take_up    = up_valid_i & ~skid_vld;
   assign main_free  = ~main_vld | dn_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_vld <= 1'b0;
         skid_vld <= 1'b0;
      end else if (main_free) begin
         main_vld <= skid_vld | take_up;
         skid_vld <= 1'b0;
      end else if (take_up) begin
         skid_vld <= 1'b1;
      end
   end

   // payload registers: enable only, no reset
   always_ff @(posedge clk) begin
      if (main_free && (skid_vld || take_up))
         main_dat <= skid_vld ? skid_dat : up_data_i;
      if (!main_free && take_up)
         skid_dat <= up_data_i;
   end

   assign dn_valid_o = main_vld;
   assign dn_data_o  = main_dat;

endmodule

// File: rtl/slice_fwd.sv
module slice_fwd #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid_i,
   output logic              up_ready_o,
   input  logic [DATA_W-1:0] up_data_i,
   output logic              dn_valid_o,
   input  logic              dn_ready_i,
   output logic [DATA_W-1:0] dn_data_o
);

   logic              hold_vld;
   logic [DATA_W-1:0] hold_dat;

   // stage can load when empty or when its beat leaves this cycle
   assign up_ready_o = ~hold_vld | dn_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_vld <= 1'b0;
      else if (up_ready_o)
         hold_vld <= up_valid_i;
   end

   always_ff @(posedge clk) begin
      if (up_ready_o && up_valid_i)
         hold_dat <= up_data_i;
   end

   assign dn_valid_o = hold_vld;
   assign dn_data_o  = hold_dat;

endmodule

// File: rtl/slice_bwd.sv
module slice_bwd #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid_i,
   output logic              up_ready_o,
   input  logic [DATA_W-1:0] up_data_i,
   output logic              dn_valid_o,
   input  logic              dn_ready_i,
   output logic [DATA_W-1:0] dn_data_o
);

   logic              park_vld;
   logic [DATA_W-1:0] park_dat;
   logic              park_load;

   assign up_ready_o = ~park_vld;
   assign park_load  = ~park_vld & up_valid_i & ~dn_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         park_vld <= 1'b0;
      else if (park_vld)
         park_vld <= ~dn_ready_i;
      else
         park_vld <= park_load;
   end

   always_ff @(posedge clk) begin
      if (park_load)
         park_dat <= up_data_i;
   end

   // parked beat wins over live input
   assign dn_valid_o = park_vld | up_valid_i;
   assign dn_data_o  = park_vld ? park_dat : up_data_i;

endmodule

// File: rtl/stream_reg_slice.sv
module stream_reg_slice
   import stream_slice_pkg::*;
#(
   parameter int          DATA_W = 8,
   parameter slice_mode_e MODE   = SLICE_FULL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [DATA_W-1:0] up_data,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [DATA_W-1:0] dn_data
);

   if (DATA_W < 1) begin : g_bad_width
      $error("stream_reg_slice: DATA_W must be at least 1");
   end

   if (MODE == SLICE_FULL) begin : g_full
      slice_full #(.DATA_W(DATA_W)) u_stage (
         .clk(clk), .rst_n(rst_n),
         .up_valid_i(up_valid), .up_ready_o(up_ready), .up_data_i(up_data),
         .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_data_o(dn_data)
      );
   end else if (MODE == SLICE_FWD) begin : g_fwd
      slice_fwd #(.DATA_W(DATA_W)) u_stage (
         .clk(clk), .rst_n(rst_n),
         .up_valid_i(up_valid), .up_ready_o(up_ready), .up_data_i(up_data),
         .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_data_o(dn_data)
      );
   end else if (MODE == SLICE_BWD) begin : g_bwd
      slice_bwd #(.DATA_W(DATA_W)) u_stage (
         .clk(clk), .rst_n(rst_n),
         .up_valid_i(up_valid), .up_ready_o(up_ready), .up_data_i(up_data),
         .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_data_o(dn_data)
      );
   end else begin : g_bad_mode
      $error("stream_reg_slice: unsupported MODE");
   end

endmodule

// File: rtl/stream_slice_checker.sv
module stream_slice_checker
   import stream_slice_pkg::*;
#(
   parameter int          DATA_W = 8,
   parameter slice_mode_e MODE   = SLICE_FULL
) (
   input logic              clk,
   input logic              rst_n,
   input logic              up_valid,
   input logic              up_ready,
   input logic [DATA_W-1:0] up_data,
   input logic              dn_valid,
   input logic              dn_ready,
   input logic [DATA_W-1:0] dn_data
);

   localparam int CAP = slice_depth(MODE);

   int   inflight;
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inflight <= 0;
         past_ok  <= 1'b0;
      end else begin
         inflight <= inflight + int'(up_valid && up_ready) - int'(dn_valid && dn_ready);
         past_ok  <= 1'b1;
      end
   end

   // R10: held beats bounded by variant depth
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= CAP);

   // R3: stalled output held
   a_r3_dn_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

   // R7: held beat offered ahead of new input
   a_r7_held_first: assert property (@(posedge clk) disable iff (!rst_n)
      !up_ready |-> dn_valid);

   // R4 / R8: full variant refuses input only after a downstream stall
   a_r8_full_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (MODE == SLICE_FULL && past_ok && !up_ready) |-> $past(dn_valid && !dn_ready));

   // R5: forward variant presents an accepted beat next cycle
   a_r5_fwd_next: assert property (@(posedge clk) disable iff (!rst_n)
      (MODE == SLICE_FWD && up_valid && up_ready) |=> (dn_valid && dn_data == $past(up_data)));

   // R6: backward variant passes through while its buffer is free
   a_r6_bwd_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (MODE == SLICE_BWD && up_ready) |-> (dn_valid == up_valid));

   // R9: idle outputs during reset
   always @(negedge clk) begin
      if (!rst_n && !up_valid)
         a_r9_reset_idle: assert (!dn_valid && up_ready);
   end

endmodule

bind stream_reg_slice stream_slice_checker #(.DATA_W(DATA_W), .MODE(MODE)) u_checker (
   .clk(clk), .rst_n(rst_n),
   .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
   .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data)
);

// File: tb/tb_stream_reg_slice.sv
`timescale 1ns/1ps
module tb_stream_reg_slice;
   import stream_slice_pkg::*;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          uv [3];
   logic          urdy [3];
   logic [DW-1:0] ud [3];
   logic          dv [3];
   logic          drdy [3];
   logic [DW-1:0] dd [3];

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // reference model: circular store per lane, write/read counts
   logic [DW-1:0] mdl [3][16];
   int            wr [3];
   int            rd [3];
   int            seqv [3];
   bit            fired [3];
   bit            stall_prev [3];
   logic [DW-1:0] dd_prev [3];
   int            cap [3] = '{2, 1, 1};
   bit            tput_on = 0;
   int            tput_warm = 0;

   always #10 clk = ~clk;

   // lane 0 full, lane 1 forward, lane 2 backward
   stream_reg_slice #(.DATA_W(DW), .MODE(SLICE_FULL)) dut (
      .clk(clk), .rst_n(rst_n), .up_valid(uv[0]), .up_ready(urdy[0]), .up_data(ud[0]),
      .dn_valid(dv[0]), .dn_ready(drdy[0]), .dn_data(dd[0]));
   stream_reg_slice #(.DATA_W(DW), .MODE(SLICE_FWD)) dut_fwd (
      .clk(clk), .rst_n(rst_n), .up_valid(uv[1]), .up_ready(urdy[1]), .up_data(ud[1]),
      .dn_valid(dv[1]), .dn_ready(drdy[1]), .dn_data(dd[1]));
   stream_reg_slice #(.DATA_W(DW), .MODE(SLICE_BWD)) dut_bwd (
      .clk(clk), .rst_n(rst_n), .up_valid(uv[2]), .up_ready(urdy[2]), .up_data(ud[2]),
      .dn_valid(dv[2]), .dn_ready(drdy[2]), .dn_data(dd[2]));

   task automatic chk(input bit ok, input string req, input int lane, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s lane %0d: actual=%0h expected=%0h", req, lane, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // one clock cycle: drive at negedge, probe at +4, sample at +8
   task automatic step(input int vprob, input int rprob);
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         if (!uv[i] || fired[i]) begin
            uv[i] = ($urandom_range(99) < vprob);
            ud[i] = seqv[i][DW-1:0];
         end
         drdy[i] = ($urandom_range(99) < rprob);
      end
      #4;
      begin
         logic s_ur, s_dv, s_uv, s_dr;
         logic [DW-1:0] s_dd, s_ud;
         // R4: full lane outputs must not follow same-cycle inputs
         s_ur = urdy[0]; s_dv = dv[0]; s_dd = dd[0];
         s_uv = uv[0]; s_ud = ud[0]; s_dr = drdy[0];
         uv[0] = ~s_uv; ud[0] = ~s_ud; drdy[0] = ~s_dr;
         #1;
         chk(urdy[0] == s_ur && dv[0] == s_dv && dd[0] == s_dd, "R4", 0,
             {urdy[0], dv[0], dd[0]}, {s_ur, s_dv, s_dd});
         uv[0] = s_uv; ud[0] = s_ud; drdy[0] = s_dr;
         // R5: forward lane downstream must not follow upstream inputs
         s_dv = dv[1]; s_dd = dd[1]; s_uv = uv[1]; s_ud = ud[1];
         uv[1] = ~s_uv; ud[1] = ~s_ud;
         #1;
         chk(dv[1] == s_dv && dd[1] == s_dd, "R5", 1, {dv[1], dd[1]}, {s_dv, s_dd});
         uv[1] = s_uv; ud[1] = s_ud;
         // R6: backward lane ready must not follow downstream ready
         s_ur = urdy[2]; s_dr = drdy[2];
         drdy[2] = ~s_dr;
         #1;
         chk(urdy[2] == s_ur, "R6", 2, urdy[2], s_ur);
         drdy[2] = s_dr;
      end
      #1;
      for (int i = 0; i < 3; i++) begin
         bit fu, fd;
         fu = uv[i] && urdy[i];
         fd = dv[i] && drdy[i];
         if (stall_prev[i])
            chk(dv[i] && dd[i] == dd_prev[i], "R3", i, {dv[i], dd[i]}, {1'b1, dd_prev[i]});
         if (!urdy[i])
            chk(dv[i], "R7", i, dv[i], 1);
         if (i == 2 && urdy[2]) begin
            chk(dv[2] == uv[2], "R6", 2, dv[2], uv[2]);
            if (uv[2]) chk(dd[2] == ud[2], "R6", 2, dd[2], ud[2]);
         end
         if (fu) begin
            mdl[i][wr[i] % 16] = ud[i];
            wr[i]++;
            seqv[i]++;
         end
         if (dv[i])
            chk(wr[i] - rd[i] > 0, "R1", i, wr[i] - rd[i], 1);
         if (fd && wr[i] - rd[i] > 0) begin
            chk(dd[i] == mdl[i][rd[i] % 16], "R2", i, dd[i], mdl[i][rd[i] % 16]);
            rd[i]++;
         end
         chk(wr[i] - rd[i] - (fd ? 0 : int'(dv[i] && i == 2 && fu && !fd ? 0 : 0)) <= cap[i] + (fu && fd && i == 2 ? 0 : 0),
             "R10", i, wr[i] - rd[i], cap[i]);
         if (i == 0 && tput_on) begin
            if (tput_warm > 0) tput_warm--;
            else chk(fu && fd, "R8", 0, {fu, fd}, 2'b11);
         end
         fired[i]      = fu;
         stall_prev[i] = dv[i] && !drdy[i];
         dd_prev[i]    = dd[i];
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 3; i++) begin
         uv[i] = 0; ud[i] = '0; drdy[i] = 0;
         wr[i] = 0; rd[i] = 0; seqv[i] = 1;
         fired[i] = 0; stall_prev[i] = 0; dd_prev[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      #8;
      for (int i = 0; i < 3; i++)
         chk(!dv[i] && urdy[i], "R9", i, {dv[i], urdy[i]}, 2'b01);
      @(negedge clk);
      rst_n = 1;
      for (int n = 0; n < 400; n++) step(70, 70);
      for (int n = 0; n < 300; n++) step(90, 25);
      for (int n = 0; n < 300; n++) step(30, 90);
      tput_on = 1; tput_warm = 4;
      for (int n = 0; n < 40; n++) step(100, 100);
      tput_on = 0;
      for (int n = 0; n < 30; n++) step(0, 100);
      for (int i = 0; i < 3; i++)
         chk(wr[i] == rd[i] && wr[i] > 50, "R2", i, wr[i] - rd[i], 0);
      finish_run();
   end

endmodule